// File: doc/BRIEF.md
# Instruction Fetch and Decode Timing Sequencer

This block is the hardwired timing and control front end of a 16-bit accumulator machine whose memory holds 4096 words. A 4-bit step counter is decoded into sixteen one-hot timing pulses. The first four pulses run a fixed schedule. The address register takes the program counter. The instruction word is read from memory and the program counter advances. The word is then split into its mode bit, opcode and address. In the fourth step either an indirect address is resolved or the instruction class is announced.

Instruction words use this layout: bit 15 is the indirect-mode bit, bits 14..12 are the opcode, and bits 11..0 are the address. Opcodes 000 to 110 are memory-reference instructions. Opcode 111 means register-reference when bit 15 is 0, and input/output when bit 15 is 1. A separate execution unit watches three class strobes. When it has finished an instruction, it pulses `exec_done`, which returns the counter to step 0 so the next fetch starts. A run flag gates all progress: while it is clear, the counter and every register hold.

Memory is read combinationally through `mem_addr` and `mem_rdata`. Memory is not part of this block.

The control state is the phase derived from the step counter:
- `PH_LOAD_AR` (step 0) goes to `PH_READ_IR`.
- `PH_READ_IR` (step 1) goes to `PH_SPLIT`.
- `PH_SPLIT` (step 2) goes to `PH_RESOLVE`.
- `PH_RESOLVE` (step 3) goes to `PH_EXEC_ENTRY`.
- `PH_EXEC_ENTRY` (step 4) goes to `PH_EXEC_WAIT`.
- `PH_EXEC_WAIT` covers steps 5 to 15 and wraps to `PH_LOAD_AR` after step 15.
- From any phase, `exec_done` returns the sequencer to `PH_LOAD_AR`.
- With the run flag clear, the sequencer stays in its current phase.

Top module: `ifd_sequencer`

## Requirements
- R1: After reset, the step counter is 0, so `t_pulse` is 16'h0001. `pc_value` and `mem_addr` are 0. `run_state` is 0, and all three class strobes are low.
- R2: `run_go` sets the run flag and `run_halt` clears it. If both are high in the same cycle, `run_halt` wins. While the run flag is 0, the step counter, `pc_value`, `mem_addr` and `instr_word` hold their values.
- R3: On the clock edge that ends step 0, the address register (`mem_addr`) loads `pc_value`.
- R4: On the clock edge that ends step 1, `instr_word` loads `mem_rdata` and `pc_value` increments by 1, wrapping from 12'hFFF to 12'h000.
- R5: On the clock edge that ends step 2, the following loads happen:
  - `mem_addr` loads bits 11..0 of `instr_word`.
  - `ind_flag` loads bit 15.
  - `op_onehot` becomes the one-hot decode of bits 14..12, where bit n is set for opcode n.
- R6: At step 3, for opcodes 000 to 110 with `ind_flag` set, `mem_addr` reloads from bits 11..0 of `mem_rdata`. For opcodes 000 to 110 with `ind_flag` clear, `mem_addr` is left unchanged.
- R7: For opcode 111 with `ind_flag` 0, `go_regref` is high during step 3.
- R8: For opcode 111 with `ind_flag` 1, `go_io` is high during step 3.
- R9: For opcodes 000 to 110, `go_memref` is high during step 4 and not during step 3. At that point `mem_addr` holds the effective address.
- R10: `exec_done` returns the counter to step 0 on the next edge, with priority over advancing. No fetch or decode register changes in that cycle.
- R11: `t_pulse` is the one-hot decode of the step counter. While the sequencer is running without `exec_done`, the counter advances once per cycle and wraps from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_go | input | 1 | Sets the run flag |
| run_halt | input | 1 | Clears the run flag (wins over run_go) |
| exec_done | input | 1 | Execution finished; counter returns to step 0 |
| mem_rdata | input | 16 | Word read from memory at mem_addr |
| mem_addr | output | 12 | Address register, drives the memory address |
| run_state | output | 1 | Run flag |
| t_pulse | output | 16 | One-hot timing pulses for steps 0..15 |
| op_onehot | output | 8 | Latched one-hot opcode decode |
| instr_word | output | 16 | Instruction register |
| pc_value | output | 12 | Program counter |
| ind_flag | output | 1 | Latched indirect-mode bit |
| go_memref | output | 1 | Memory-reference execution strobe (step 4) |
| go_regref | output | 1 | Register-reference execution strobe (step 3) |
| go_io | output | 1 | Input/output execution strobe (step 3) |

## Verification
The bench builds the block with its default parameters: a 12-bit address and a 4-bit step counter. With a 12-bit address, the bench can fetch every one of the 4096 memory words in turn and then fetch address 0 again, so it reaches the program counter's wrap from 12'hFFF to 12'h000 and sees every opcode and mode combination against varied indirect pointers. With a 4-bit counter, a run with no `exec_done` wraps past step 15 within sixteen cycles. The bench also exercises halt priority, the hold while stopped, and an `exec_done` that lands on step 1.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

    // Phase of the fetch/decode schedule, derived from the step counter
    typedef enum logic [2:0] {
        PH_LOAD_AR,
        PH_READ_IR,
        PH_SPLIT,
        PH_RESOLVE,
        PH_EXEC_ENTRY,
        PH_EXEC_WAIT
    } phase_e;

    localparam int OPCODE_W = 3;

endpackage

// File: rtl/ifd_seq_counter.sv
module ifd_seq_counter #(
    parameter int SC_W = 4,
    localparam int NUM_T = 1 << SC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             clr,
    output logic [SC_W-1:0]  sc,
    output logic [NUM_T-1:0] t_pulse
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sc <= '0;
        else if (clr)
            sc <= '0;
        else if (adv)
            sc <= sc + 1'b1;
    end

    // one-hot step decoder
    generate
        for (genvar g = 0; g < NUM_T; g++) begin : g_tdec
            assign t_pulse[g] = (sc == SC_W'(g));
        end
    endgenerate

    AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> t_pulse[0]); // R10

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !adv) |=> $stable(t_pulse)); // R2

endmodule

// File: rtl/ifd_op_decoder.sv
module ifd_op_decoder #(
    parameter int OP_W = 3,
    localparam int NUM_D = 1 << OP_W
) (
    input  logic [OP_W-1:0]  op,
    output logic [NUM_D-1:0] dec
);

    generate
        for (genvar g = 0; g < NUM_D; g++) begin : g_ddec
            assign dec[g] = (op == OP_W'(g));
        end
    endgenerate

endmodule

// File: rtl/ifd_sequencer.sv
module ifd_sequencer
    import ifd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SC_W = 4,
    localparam int DATA_W = ADDR_W + 1 + OPCODE_W,
    localparam int NUM_T = 1 << SC_W,
    localparam int NUM_D = 1 << OPCODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_go,
    input  logic              run_halt,
    input  logic              exec_done,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              run_state,
    output logic [NUM_T-1:0]  t_pulse,
    output logic [NUM_D-1:0]  op_onehot,
    output logic [DATA_W-1:0] instr_word,
    output logic [ADDR_W-1:0] pc_value,
    output logic              ind_flag,
    output logic              go_memref,
    output logic              go_regref,
    output logic              go_io
);

    localparam int I_BIT  = DATA_W - 1;
    localparam int OP_TOP = DATA_W - 2;

    logic              run_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] ar_q;
    logic [DATA_W-1:0] ir_q;
    logic              i_q;
    logic [NUM_D-1:0]  d_q;
    logic [NUM_D-1:0]  dec_w;
    logic [SC_W-1:0]   sc;
    logic              step;
    logic              d_top;
    phase_e            phase;

    assign step  = run_q && !exec_done;
    assign d_top = d_q[NUM_D-1];

    ifd_seq_counter #(.SC_W(SC_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (run_q),
        .clr     (exec_done),
        .sc      (sc),
        .t_pulse (t_pulse)
    );

    ifd_op_decoder #(.OP_W(OPCODE_W)) u_opdec (
        .op  (ir_q[OP_TOP -: OPCODE_W]),
        .dec (dec_w)
    );

    // phase naming of the step counter
    always_comb begin
        unique case (sc)
            SC_W'(0): phase = PH_LOAD_AR;
            SC_W'(1): phase = PH_READ_IR;
            SC_W'(2): phase = PH_SPLIT;
            SC_W'(3): phase = PH_RESOLVE;
            SC_W'(4): phase = PH_EXEC_ENTRY;
            default:  phase = PH_EXEC_WAIT;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            pc_q  <= '0;
            ar_q  <= '0;
            ir_q  <= '0;
            i_q   <= 1'b0;
            d_q   <= '0;
        end else begin
            if (run_halt)
                run_q <= 1'b0;
            else if (run_go)
                run_q <= 1'b1;
            if (step) begin
                unique case (phase)
                    PH_LOAD_AR: ar_q <= pc_q;
                    PH_READ_IR: begin
                        ir_q <= mem_rdata;
                        pc_q <= pc_q + 1'b1;
                    end
                    PH_SPLIT: begin
                        ar_q <= ir_q[ADDR_W-1:0];
                        i_q  <= ir_q[I_BIT];
                        d_q  <= dec_w;
                    end
                    PH_RESOLVE: begin
                        if (!d_top && i_q)
                            ar_q <= mem_rdata[ADDR_W-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    // output process: class strobes
    always_comb begin
        go_memref = 1'b0;
        go_regref = 1'b0;
        go_io     = 1'b0;
        if (run_q) begin
            unique case (phase)
                PH_RESOLVE: begin
                    go_regref = d_top && !i_q;
                    go_io     = d_top && i_q;
                end
                PH_EXEC_ENTRY: go_memref = !d_top;
                default: ;
            endcase
        end
    end

    assign mem_addr   = ar_q;
    assign run_state  = run_q;
    assign op_onehot  = d_q;
    assign instr_word = ir_q;
    assign pc_value   = pc_q;
    assign ind_flag   = i_q;

    AST_AR_TAKES_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state && !exec_done && t_pulse[0]) |=> mem_addr == $past(pc_value)); // R3

    AST_PC_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state && !exec_done && t_pulse[1]) |=> pc_value == $past(pc_value) + 1'b1); // R4

    AST_IR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state && !exec_done && t_pulse[1]) |=> instr_word == $past(mem_rdata)); // R4

    AST_INDIRECT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state && !exec_done && t_pulse[3] && !op_onehot[NUM_D-1] && ind_flag)
        |=> mem_addr == $past(mem_rdata[ADDR_W-1:0])); // R6

    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_memref, go_regref, go_io})); // R7

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run_state |=> ($stable(pc_value) && $stable(mem_addr) && $stable(instr_word))); // R2

    AST_HALT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        run_halt |=> !run_state); // R2

endmodule

// File: tb/test_ifd_sequencer.sv
`timescale 1ns/1ps
module test_ifd_sequencer;

    localparam int AW = 12;
    localparam int DW = 16;
    localparam int NT = 16;
    localparam int MEMN = 1 << AW;
    localparam int TOTAL = MEMN + 1;

    typedef struct packed {
        logic [1:0]    cls;   // 1 memref, 2 regref, 3 io
        logic [DW-1:0] ir;
        logic [AW-1:0] ar;
        logic [AW-1:0] pc;
        logic          ind;
        logic [3:0]    tix;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_go = 1'b0;
    logic run_halt = 1'b0;
    logic exec_done = 1'b0;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] mem_addr;
    logic run_state;
    logic [NT-1:0] t_pulse;
    logic [7:0] op_onehot;
    logic [DW-1:0] instr_word;
    logic [AW-1:0] pc_value;
    logic ind_flag, go_memref, go_regref, go_io;

    logic [DW-1:0] mem [0:MEMN-1];
    exp_t sb_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    logic mon_en = 1'b0;

    always #10 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    ifd_sequencer i_ifd_sequencer (
        .clk(clk), .rst_n(rst_n), .run_go(run_go), .run_halt(run_halt),
        .exec_done(exec_done), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .run_state(run_state), .t_pulse(t_pulse), .op_onehot(op_onehot),
        .instr_word(instr_word), .pc_value(pc_value), .ind_flag(ind_flag),
        .go_memref(go_memref), .go_regref(go_regref), .go_io(go_io)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_expected(input int a);
        exp_t e;
        logic [DW-1:0] w;
        w = mem[a];
        e.ir  = w;
        e.pc  = AW'(a + 1);
        e.ind = w[15];
        if (w[14:12] != 3'b111) begin
            e.cls = 2'd1;
            e.tix = 4'd4;
            e.ar  = w[15] ? mem[w[11:0]][11:0] : w[11:0];
        end else begin
            e.cls = w[15] ? 2'd3 : 2'd2;
            e.tix = 4'd3;
            e.ar  = w[11:0];
        end
        sb_q.push_back(e);
    endtask

    // monitor: pop and compare whenever a class strobe appears
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && (go_memref || go_regref || go_io)) begin
                if (sb_q.size() == 0) begin
                    check("R9", "unexpected strobe", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    logic [1:0] acls;
                    string creq;
                    e = sb_q.pop_front();
                    acls = go_memref ? 2'd1 : (go_regref ? 2'd2 : 2'd3);
                    creq = (e.cls == 2'd1) ? "R9" : ((e.cls == 2'd2) ? "R7" : "R8");
                    check(creq, "class", 32'(acls), 32'(e.cls));
                    check(creq, "step", 32'(t_pulse), 32'(1 << e.tix));
                    check("R4", "instr_word", 32'(instr_word), 32'(e.ir));
                    check("R4", "pc_value", 32'(pc_value), 32'(e.pc));
                    check("R6", "effective addr", 32'(mem_addr), 32'(e.ar));
                    check("R5", "ind_flag", 32'(ind_flag), 32'(e.ind));
                    check("R5", "op_onehot", 32'(op_onehot), 32'(1 << e.ir[14:12]));
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seen;
        logic [AW-1:0] pc_hold;
        logic [AW-1:0] ar_hold;
        for (int a = 0; a < MEMN; a++) mem[a] = DW'((a * 40503) ^ 23130);
        mem[0] = 16'h1234;
        mem[1] = 16'h9050;
        mem[2] = 16'h7800;
        mem[3] = 16'hF400;
        mem[4] = 16'hE7FF;
        mem[5] = 16'h7001;
        mem[12'h050] = 16'hF0AB;
        mem[12'h7FF] = 16'h1ABC;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "t_pulse", 32'(t_pulse), 32'h1);
        check("R1", "pc_value", 32'(pc_value), 32'h0);
        check("R1", "mem_addr", 32'(mem_addr), 32'h0);
        check("R1", "run_state", 32'(run_state), 32'h0);
        check("R1", "strobes", 32'({go_memref, go_regref, go_io}), 32'h0);
        rst_n = 1'b1;
        // R2 hold while stopped
        repeat (4) @(negedge clk);
        check("R2", "t_pulse held", 32'(t_pulse), 32'h1);
        check("R2", "pc held", 32'(pc_value), 32'h0);

        // scoreboard run over every address, then address 0 again
        for (int a = 0; a < MEMN; a++) push_expected(a);
        push_expected(0);
        mon_en = 1'b1;
        run_go = 1'b1;
        @(negedge clk);
        run_go = 1'b0;
        seen = 0;
        while (seen < TOTAL) begin
            @(negedge clk);
            if (go_memref || go_regref || go_io) begin
                seen++;
                exec_done = 1'b1;
                run_halt = (seen == TOTAL);
            end else begin
                exec_done = 1'b0;
            end
        end
        @(negedge clk);
        exec_done = 1'b0;
        run_halt = 1'b0;
        mon_en = 1'b0;
        check("R4", "queue drained", 32'(sb_q.size()), 32'd0);
        // R2/R10 after halt with done: stopped at step 0, pc past address 0
        check("R2", "run_state after halt", 32'(run_state), 32'h0);
        check("R10", "t_pulse after done", 32'(t_pulse), 32'h1);
        check("R4", "pc after wrap", 32'(pc_value), 32'h1);
        pc_hold = pc_value;
        ar_hold = mem_addr;
        repeat (5) @(negedge clk);
        check("R2", "pc stable stopped", 32'(pc_value), 32'(pc_hold));
        check("R2", "ar stable stopped", 32'(mem_addr), 32'(ar_hold));

        // R2 halt beats go
        run_go = 1'b1;
        run_halt = 1'b1;
        @(negedge clk);
        run_go = 1'b0;
        run_halt = 1'b0;
        check("R2", "halt priority", 32'(run_state), 32'h0);

        // R11 free run without done; directed R3..R6, R9 on word at address 1
        run_go = 1'b1;
        @(negedge clk);
        run_go = 1'b0;
        check("R2", "go sets run", 32'(run_state), 32'h1);
        check("R11", "step 0", 32'(t_pulse), 32'h1);
        for (int k = 1; k < 20; k++) begin
            @(negedge clk);
            check("R11", "step pulse", 32'(t_pulse), 32'(1 << (k % 16)));
            if (k == 1) check("R3", "ar from pc", 32'(mem_addr), 32'h1);
            if (k == 2) begin
                check("R4", "pc incremented", 32'(pc_value), 32'h2);
                check("R4", "ir loaded", 32'(instr_word), 32'h9050);
            end
            if (k == 3) begin
                check("R5", "ar from ir", 32'(mem_addr), 32'h050);
                check("R5", "ind bit", 32'(ind_flag), 32'h1);
                check("R9", "no memref at step 3", 32'(go_memref), 32'h0);
            end
            if (k == 4) begin
                check("R6", "indirect ar", 32'(mem_addr), 32'h0AB);
                check("R9", "memref at step 4", 32'(go_memref), 32'h1);
            end
        end

        // R10 done on step 1 suppresses the fetch
        while (!t_pulse[1]) @(negedge clk);
        pc_hold = pc_value;
        exec_done = 1'b1;
        @(negedge clk);
        exec_done = 1'b0;
        check("R10", "cleared to step 0", 32'(t_pulse), 32'h1);
        check("R10", "pc not incremented", 32'(pc_value), 32'(pc_hold));
        run_halt = 1'b1;
        @(negedge clk);
        run_halt = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule